// File: doc/BRIEF.md
# Receive Frame Status and Word Readout Port

This block sits between a MAC receiver and a host bus. Received bytes arrive one per cycle with a marker on the last byte of each frame, and error and class bits that travel with that last byte. The block packs the bytes into 32-bit words for the host and keeps one status entry for each completed frame in a small status queue.

The host polls a status register. While a frame is still arriving, the status shows how many of its bytes have come in so far. Once the frame has ended, the status shows a done flag together with the final length, error and class. Reading a done status retires that entry, so the host can look at the next frame even if it has not yet fetched all the data of the current one. Frame data is fetched word by word from a separate data register. Data reads never change the reported byte counts.

Top module: `rx_frame_port`

## Requirements
- R1: After reset, `st_word` and `dat_word` are zero and `dat_underflow` is low.
- R2: A status read when no byte of any frame is held returns all zero. A count of zero means no new frame.
- R3: While a frame is arriving and no completed frame is queued, a status read returns the number of bytes accepted so far in bits 15:0. Bit 31 (done) is 0 and bits 30:16 are 0.
- R4: A status read of a completed frame returns done=1 in bit 31, the class in bits 30:24, the error bits in bits 23:16 and the frame length in bits 15:0.
- R5: A status read that returns done=1 retires that frame's entry. The next status read refers to the next frame, whether or not the first frame's data has been read.
- R6: Reading data never reduces the byte count seen in the status.
- R7: Bytes are packed little-endian. Byte 0 of a frame goes in bits 7:0 of its first word, and byte k goes in bits 8*(k mod 4)+7 : 8*(k mod 4) of word k/4.
- R8: When a frame's length is not a multiple of 4, the unused upper bytes of its last word read as zero. The next frame always starts in a fresh word.
- R9: A data read when no packed word is available returns zero and sets `dat_underflow`. The flag stays high until reset.
- R10: Completed frames are reported and their words are returned in arrival order, with several frames queued at once.
- R11: `st_word` and `dat_word` are registered. Each takes its new value in the cycle after its read strobe and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A receive byte is present this cycle |
| in_byte | input | 8 | Receive byte |
| in_last | input | 1 | This byte ends its frame |
| in_err | input | 8 | Error bits of the frame, sampled with the last byte |
| in_class | input | 7 | Class bits of the frame, sampled with the last byte |
| st_rd | input | 1 | Status read strobe |
| st_word | output | 32 | Status word from the latest status read |
| dat_rd | input | 1 | Data read strobe |
| dat_word | output | 32 | Data word from the latest data read |
| dat_underflow | output | 1 | Sticky flag: a data read found no word available |

## Verification
The in-RTL assertions check, on every cycle, that:
- the running count never drops except when a frame completes;
- a done status always carries a nonzero length, and a zero count carries no other bits;
- the underflow flag, once set, stays set;
- both output registers hold between read strobes;
- no queue is pushed while full.

Only the bench scenarios can show the value-level behaviour:
- packing order and zero padding;
- retiring a status entry while its frame's data is still unread;
- a live count shown behind an already completed frame;
- the ordering of several queued frames.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int ERR_W  = 8;
  localparam int CLS_W  = 7;

  // one completed-frame entry; with the done bit on top it fills a word
  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [ERR_W-1:0] err;
    logic [CNT_W-1:0] len;
  } stat_ent_t;
endpackage

// File: rtl/rxp_fifo.sv
// Synchronous FIFO with a show-ahead head output. DEPTH must be a power of two.
module rxp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rp];
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);

  // R10: occupancy stays within the storage
  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/rxp_packer.sv
// Gathers bytes little-endian into words; a frame end flushes a zero-padded word.
module rxp_packer
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  output logic              push,
  output logic [WORD_W-1:0] word
);
  localparam int BYTES = WORD_W / 8;
  localparam int LW    = $clog2(BYTES);

  logic [LW-1:0]     lane;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] merged;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign merged[8*g +: 8] = (lane == LW'(g)) ? in_byte :
                              ((LW'(g) < lane) ? acc[8*g +: 8] : 8'h00);
  end

  assign push = in_valid && (in_last || lane == LW'(BYTES-1));
  assign word = merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane <= '0;
      acc  <= '0;
    end else if (in_valid) begin
      if (push) begin
        lane <= '0;
        acc  <= '0;
      end else begin
        lane <= lane + 1'b1;
        acc  <= merged;
      end
    end
  end

  // R8: a one-byte flush leaves every padding byte zero
  a_r8_single_byte_pad: assert property (@(posedge clk) disable iff (rst)
    (push && lane == '0) |-> (word[WORD_W-1:8] == '0));
  // R8: a flush always restarts the next frame or word at lane 0
  a_r8_fresh_lane: assert property (@(posedge clk) disable iff (rst)
    push |=> (lane == '0));
endmodule

// File: rtl/rxp_status.sv
// Running byte count, completed-frame status queue and the host status register.
module rxp_status
  import rxp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [ERR_W-1:0]  in_err,
  input  logic [CLS_W-1:0]  in_cls,
  input  logic              st_rd,
  output logic [WORD_W-1:0] st_word
);
  localparam int EW  = $bits(stat_ent_t);
  localparam int PAD = WORD_W - 1 - CNT_W;

  logic [CNT_W-1:0]  live_cnt;
  stat_ent_t         ent_in, ent_head;
  logic [EW-1:0]     head_raw;
  logic              f_push, f_pop, f_full, f_empty;
  logic [WORD_W-1:0] view;

  always_comb begin
    ent_in.cls = in_cls;
    ent_in.err = in_err;
    ent_in.len = live_cnt + CNT_W'(1);
  end

  assign f_push   = in_valid && in_last;
  assign f_pop    = st_rd && !f_empty;
  assign ent_head = stat_ent_t'(head_raw);

  rxp_fifo #(.W(EW), .DEPTH(DEPTH)) u_stat_q (
    .clk   (clk),
    .rst   (rst),
    .push  (f_push),
    .din   (ent_in),
    .pop   (f_pop),
    .head  (head_raw),
    .full  (f_full),
    .empty (f_empty)
  );

  always_ff @(posedge clk) begin
    if (rst)          live_cnt <= '0;
    else if (f_push)  live_cnt <= '0;
    else if (in_valid) live_cnt <= live_cnt + 1'b1;
  end

  always_comb begin
    if (f_empty) view = {1'b0, {PAD{1'b0}}, live_cnt};
    else         view = {1'b1, ent_head};
  end

  always_ff @(posedge clk) begin
    if (rst)        st_word <= '0;
    else if (st_rd) st_word <= view;
  end

  // R6: the running count only falls when a frame completes
  a_r6_count_never_drops: assert property (@(posedge clk) disable iff (rst)
    !$past(f_push) |-> (live_cnt >= $past(live_cnt)));
  // R4: a done status always carries a nonzero length
  a_r4_done_has_len: assert property (@(posedge clk) disable iff (rst)
    st_word[WORD_W-1] |-> (st_word[CNT_W-1:0] != '0));
  // R2: a zero count carries no flag or field bits
  a_r2_zero_is_empty: assert property (@(posedge clk) disable iff (rst)
    (st_word[CNT_W-1:0] == '0) |-> (st_word == '0));
  // R11: the status register holds between reads
  a_r11_status_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(st_rd) |-> $stable(st_word));
  // R10: no completed frame is lost to a full status queue
  a_r10_stat_room: assert property (@(posedge clk) disable iff (rst)
    f_push |-> !f_full);
endmodule

// File: rtl/rx_frame_port.sv
module rx_frame_port
  import rxp_pkg::*;
#(
  parameter int DATA_DEPTH = 64,
  parameter int STAT_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  input  logic [ERR_W-1:0]  in_err,
  input  logic [CLS_W-1:0]  in_class,
  input  logic              st_rd,
  output logic [WORD_W-1:0] st_word,
  input  logic              dat_rd,
  output logic [WORD_W-1:0] dat_word,
  output logic              dat_underflow
);
  logic              pk_push;
  logic [WORD_W-1:0] pk_word, d_head;
  logic              d_pop, d_full, d_empty;

  rxp_packer u_pack (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .in_last  (in_last),
    .push     (pk_push),
    .word     (pk_word)
  );

  rxp_fifo #(.W(WORD_W), .DEPTH(DATA_DEPTH)) u_data_q (
    .clk   (clk),
    .rst   (rst),
    .push  (pk_push),
    .din   (pk_word),
    .pop   (d_pop),
    .head  (d_head),
    .full  (d_full),
    .empty (d_empty)
  );

  rxp_status #(.DEPTH(STAT_DEPTH)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_err   (in_err),
    .in_cls   (in_class),
    .st_rd    (st_rd),
    .st_word  (st_word)
  );

  assign d_pop = dat_rd && !d_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_word      <= '0;
      dat_underflow <= 1'b0;
    end else if (dat_rd) begin
      dat_word <= d_pop ? d_head : '0;
      if (!d_pop) dat_underflow <= 1'b1;
    end
  end

  // R9: the underflow flag is sticky
  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(dat_underflow) |-> dat_underflow);
  // R9: an empty read returns a zero word
  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(dat_rd) && $past(d_empty)) |-> (dat_word == '0));
  // R11: the data register holds between reads
  a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(dat_rd) |-> $stable(dat_word));
  // R10: no packed word is lost to a full data queue
  a_r10_data_room: assert property (@(posedge clk) disable iff (rst)
    pk_push |-> !d_full);
endmodule

// File: tb/rx_frame_port_tb_top.sv
module rx_frame_port_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_last, st_rd, dat_rd;
  logic [7:0]  in_byte, in_err;
  logic [6:0]  in_class;
  logic [31:0] st_word, dat_word;
  logic        dat_underflow;

  always #5 clk = ~clk;

  rx_frame_port dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_err(in_err), .in_class(in_class),
    .st_rd(st_rd), .st_word(st_word), .dat_rd(dat_rd),
    .dat_word(dat_word), .dat_underflow(dat_underflow)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_data[$];
  logic [31:0] exp_stat[$];
  logic [31:0] acc_m = '0;
  int lane_m = 0;
  int live_m = 0;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // driver: one byte per cycle, with the expected words and status queued
  task automatic put_byte(logic [7:0] b, bit last, logic [7:0] er, logic [6:0] cl);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_last = last; in_err = er; in_class = cl;
    acc_m = acc_m | (32'(b) << (8 * lane_m));
    live_m++;
    if (lane_m == 3 || last) begin
      exp_data.push_back(acc_m);
      acc_m = '0;
      lane_m = 0;
    end else lane_m++;
    if (last) begin
      exp_stat.push_back({1'b1, cl, er, 16'(live_m)});
      live_m = 0;
    end
  endtask

  task automatic send(int start, int n, int seed, bit with_last,
                      logic [7:0] er, logic [6:0] cl);
    for (int i = start; i < start + n; i++)
      put_byte(8'(seed * 16 + i * 3 + 1), with_last && (i == start + n - 1), er, cl);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic rd_status(string rq, logic [31:0] exp);
    @(negedge clk); st_rd = 1'b1;
    @(negedge clk); st_rd = 1'b0;
    chk(rq, st_word, exp);
  endtask

  // monitor side: each status/data read pops the scoreboard and compares
  task automatic rd_status_q(string rq);
    logic [31:0] e;
    e = (exp_stat.size() > 0) ? exp_stat.pop_front() : 32'h0;
    rd_status(rq, e);
  endtask

  task automatic rd_data_q(string rq);
    logic [31:0] e;
    e = (exp_data.size() > 0) ? exp_data.pop_front() : 32'h0;
    @(negedge clk); dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
    chk(rq, dat_word, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_last = 0; in_byte = 0; in_err = 0; in_class = 0;
    st_rd = 0; dat_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 st_word", st_word, 32'h0);
    chk("R1 dat_word", dat_word, 32'h0);
    chk("R1 underflow", 32'(dat_underflow), 32'h0);
    rd_status("R2 idle status", 32'h0);

    // partial frame: live count, packing, count unaffected by data read
    send(0, 5, 0, 1'b0, 8'h00, 7'h00);
    rd_data_q("R7 first word little-endian");
    rd_status("R3 R6 live count after data read", 32'd5);
    send(5, 2, 0, 1'b1, 8'h3c, 7'h15);
    rd_status_q("R4 done status fields");
    rd_status("R5 entry retired", 32'h0);
    rd_data_q("R8 padded last word");

    // three queued frames, statuses retired before any data is read
    send(0, 4, 1, 1'b1, 8'h00, 7'h11);
    send(0, 1, 2, 1'b1, 8'h5a, 7'h7f);
    send(0, 9, 3, 1'b1, 8'h81, 7'h02);
    rd_status_q("R10 first queued frame");
    rd_status_q("R5 next frame with data unread");
    rd_status_q("R10 third queued frame");
    rd_status("R2 status queue drained", 32'h0);
    for (int k = 0; k < 5; k++) rd_data_q("R10 R7 R8 queued words in order");

    // status register holds while bytes arrive without a read
    send(0, 6, 4, 1'b1, 8'h42, 7'h33);
    chk("R11 status held without read", st_word, 32'h0);
    send(0, 3, 5, 1'b0, 8'h00, 7'h00);
    rd_status_q("R10 completed frame ahead of live one");
    rd_status("R3 live count behind completed frame", 32'd3);
    send(3, 2, 5, 1'b1, 8'h07, 7'h40);
    rd_status_q("R4 live frame now done");
    for (int k = 0; k < 4; k++) rd_data_q("R7 R8 later frame words");
    chk("R9 no underflow yet", 32'(dat_underflow), 32'h0);

    rd_data_q("R9 empty read returns zero");
    chk("R9 underflow set", 32'(dat_underflow), 32'h1);
    rd_status("R2 idle after all frames", 32'h0);
    chk("R9 underflow sticky", 32'(dat_underflow), 32'h1);
    chk("R11 data word held", dat_word, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule